// File: doc/BRIEF.md
# Ping-Pong Stack Reverse Delay Path

This block supplies the reverse-direction sample stream for a decimating symmetric filter. Two last-in-first-out stacks work in turn. One of them collects the samples that arrive from the forward path. At the same time, the other one replays the batch it collected earlier, newest sample first, onto the reverse output. Across a decimation period this gives the mirrored ordering that a folded symmetric filter needs. The filter pairs each forward sample with its mirror partner on the reverse output.

The input port registers every control and data input on the rising clock edge. A falling edge of the registered transfer control swaps the two stacks. The stack that was collecting starts to replay, and the stack that was replaying is emptied and starts to collect. While the freeze input is high, no sample is pushed or popped and the output holds its value. Transfer edges are still tracked during a freeze. A read from an empty replay stack gives zero and raises a flag.

Top module: `lifo_reverse_path`

## Requirements
- R1: After synchronous reset, `rev_sample` is 0 and `rev_empty_read` is 0. Stack 0 collects and both stacks are empty. The registered transfer history is low, so a low `xfer` right after reset causes no swap.
- R2: `fwd_sample`, `freeze` and `xfer` are registered on the rising clock edge. Their effect shows on `rev_sample` and `rev_empty_read` after the second rising edge. When the registered freeze is low, that cycle pushes one sample into the collecting stack and pops one sample from the replaying stack.
- R3: The stacks swap roles in the cycle whose registered `xfer` is 0 after a registered `xfer` of 1. The pop in that same cycle already comes from the newly replaying stack, which returns its samples newest first.
- R4: A rising edge of `xfer` never swaps. Holding `xfer` low after a swap causes no further swap. A new swap needs `xfer` to go high and then low again.
- R5: At a swap the newly collecting stack is emptied, and any samples it had not yet replayed are discarded. The sample pushed in the swap cycle becomes its only entry.
- R6: A pop from an empty replay stack drives `rev_sample` to 0 and `rev_empty_read` to 1. A pop that returns a stored sample drives `rev_empty_read` to 0.
- R7: While the registered freeze is 1, no push or pop happens and `rev_sample` and `rev_empty_read` hold their values. A transfer edge seen during the freeze still swaps the stacks.
- R8: Each stack holds DEPTH samples (16 by default). Pushes into a full collecting stack are dropped. All DEPTH stored samples replay newest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fwd_sample | input | DATA_W | Sample arriving from the forward decimation path |
| freeze | input | 1 | High holds both stacks and the output |
| xfer | input | 1 | Transfer control; a registered high-to-low edge swaps the stacks |
| rev_sample | output | DATA_W | Sample replayed into the reverse path |
| rev_empty_read | output | 1 | High when the last pop found the replay stack empty |

## Verification
The hardest case to reach is a transfer edge that happens during a freeze, while the replay stack still holds unread samples. The swap must take effect even though no data moves, and the leftover samples must be lost. The stimulus stops a replay partway through, raises freeze, and toggles `xfer` high and then low under the freeze. It then releases the freeze and checks that the output continues from the other stack. It also checks that the abandoned samples never reappear. A second sequence overfills one stack by five samples. It then replays the stack completely to show that exactly DEPTH samples come back, newest first.

// File: rtl/lifo_rev_pkg.sv
package lifo_rev_pkg;

    localparam int DEF_DATA_W = 10;
    localparam int DEF_DEPTH  = 16;

    // Registered control inputs of one cycle
    typedef struct packed {
        logic freeze;
        logic xfer;
    } ctl_t;

    // Which of the two stacks is meant
    typedef enum logic {
        BANK0 = 1'b0,
        BANK1 = 1'b1
    } bank_e;

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK0) ? BANK1 : BANK0;
    endfunction

endpackage

// File: rtl/lifo_stack.sv
module lifo_stack #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] top_data,
    output logic              empty,
    output logic [CNT_W-1:0]  level
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  cnt_d;
    logic [CNT_W-1:0]  top_idx;
    logic              do_write;

    // A clear restarts the stack; a push in the same cycle lands in slot 0
    always_comb begin
        base     = clr ? '0 : cnt_q;
        do_write = push && (base < CNT_W'(DEPTH));
        cnt_d    = base;
        if (do_write)
            cnt_d = base + 1'b1;
        else if (pop && (base != '0))
            cnt_d = base - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
        if (do_write)
            mem[base[IDX_W-1:0]] <= wr_data;
    end

    assign top_idx  = cnt_q - 1'b1;
    assign empty    = (cnt_q == '0);
    assign top_data = empty ? '0 : mem[top_idx[IDX_W-1:0]];
    assign level    = cnt_q;

endmodule

// File: rtl/xfer_ctl.sv
module xfer_ctl
    import lifo_rev_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  xfer_q,
    output logic  swap,
    output bank_e sel_q,
    output bank_e recv_bank
);

    logic xfer_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_prev <= 1'b0;
            sel_q     <= BANK0;
        end else begin
            xfer_prev <= xfer_q;
            if (swap)
                sel_q <= other_bank(sel_q);
        end
    end

    // Only a high-to-low step of the registered control exchanges the roles
    assign swap      = xfer_prev & ~xfer_q;
    assign recv_bank = swap ? other_bank(sel_q) : sel_q;

endmodule

// File: rtl/lifo_reverse_path.sv
module lifo_reverse_path
    import lifo_rev_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] fwd_sample,
    input  logic              freeze,
    input  logic              xfer,
    output logic [DATA_W-1:0] rev_sample,
    output logic              rev_empty_read
);

    ctl_t              ctl_q;
    logic [DATA_W-1:0] din_q;
    logic              frz_q;
    logic              swap;
    bank_e             sel_q;
    bank_e             recv_bank;
    bank_e             send_bank;
    logic              send_idx;
    logic              sel_idx;

    logic [DATA_W-1:0] top_w   [2];
    logic [CNT_W-1:0]  level_w [2];
    logic [1:0]        empty_w;
    logic [CNT_W-1:0]  recv_level;

    // Input register stage; freeze comes out of reset asserted
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{freeze: 1'b1, xfer: 1'b0};
            din_q <= '0;
        end else begin
            ctl_q <= '{freeze: freeze, xfer: xfer};
            din_q <= fwd_sample;
        end
    end

    assign frz_q = ctl_q.freeze;

    xfer_ctl u_xfer (
        .clk       (clk),
        .rst       (rst),
        .xfer_q    (ctl_q.xfer),
        .swap      (swap),
        .sel_q     (sel_q),
        .recv_bank (recv_bank)
    );

    assign send_bank = other_bank(recv_bank);
    assign send_idx  = send_bank;
    assign sel_idx   = sel_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam bank_e BANK_ID = bank_e'(b);
        lifo_stack #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_stack (
            .clk      (clk),
            .rst      (rst),
            .clr      (swap && (recv_bank == BANK_ID)),
            .push     (!frz_q && (recv_bank == BANK_ID)),
            .pop      (!frz_q && (send_bank == BANK_ID)),
            .wr_data  (din_q),
            .top_data (top_w[b]),
            .empty    (empty_w[b]),
            .level    (level_w[b])
        );
    end

    assign recv_level = level_w[sel_idx];

    // Output register: replay stack top, or zero with the empty flag
    always_ff @(posedge clk) begin
        if (rst) begin
            rev_sample     <= '0;
            rev_empty_read <= 1'b0;
        end else if (!frz_q) begin
            rev_sample     <= empty_w[send_idx] ? '0 : top_w[send_idx];
            rev_empty_read <= empty_w[send_idx];
        end
    end

endmodule

module lifo_reverse_path_chk #(
    parameter int DATA_W = 10,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer,
    input logic              frz_q,
    input logic              sel_q,
    input logic [CNT_W-1:0]  recv_level,
    input logic [DATA_W-1:0] rev_sample,
    input logic              rev_empty_read
);

    // R6: an empty read always shows zero data
    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        rev_empty_read |-> (rev_sample == '0));

    // R7: a frozen cycle leaves the output untouched
    a_r7_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        frz_q |=> ($stable(rev_sample) && $stable(rev_empty_read)));

    // R4: a role change follows a high-then-low pair of samples on xfer
    a_r4_swap_needs_fall: assert property (@(posedge clk) disable iff (rst)
        (sel_q != $past(sel_q)) |-> ($past(xfer, 3) && !$past(xfer, 2)));

    // R5: a freshly collecting stack holds at most the sample of the swap cycle
    a_r5_fresh_receiver: assert property (@(posedge clk) disable iff (rst)
        (sel_q != $past(sel_q)) |-> (recv_level <= CNT_W'(1)));

endmodule

bind lifo_reverse_path lifo_reverse_path_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .xfer           (xfer),
    .frz_q          (frz_q),
    .sel_q          (sel_idx),
    .recv_level     (recv_level),
    .rev_sample     (rev_sample),
    .rev_empty_read (rev_empty_read)
);

// File: tb/lifo_reverse_path_bench.sv
module lifo_reverse_path_bench;

    localparam int W = 10;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] fwd_sample = '0;
    logic         freeze = 1'b1;
    logic         xfer = 1'b0;
    logic [W-1:0] rev_sample;
    logic         rev_empty_read;

    lifo_reverse_path #(.DATA_W(W), .DEPTH(D)) u_lifo_reverse_path (
        .clk            (clk),
        .rst            (rst),
        .fwd_sample     (fwd_sample),
        .freeze         (freeze),
        .xfer           (xfer),
        .rev_sample     (rev_sample),
        .rev_empty_read (rev_empty_read)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [W-1:0] val;
        logic         uf;
        int           due;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;

    // Behavioural reference of the requirements
    logic [W-1:0] m_mem [2][D];
    int           m_cnt [2] = '{0, 0};
    int           m_recv = 0;
    logic         m_prev = 1'b0;
    logic [W-1:0] m_out = '0;
    logic         m_uf = 1'b0;

    task automatic check(input string tag, input logic [W-1:0] av, input logic au,
                         input logic [W-1:0] ev, input logic eu);
        checks++;
        if (av !== ev || au !== eu) begin
            fails++;
            $display("FAIL %s: rev_sample=%0d empty_read=%0b expected %0d/%0b",
                     tag, av, au, ev, eu);
        end
    endtask

    // Driver: applies one cycle of inputs and queues the expected result
    task automatic step(input logic [W-1:0] d, input logic f, input logic x, input string tag);
        int s;
        @(negedge clk);
        fwd_sample = d;
        freeze     = f;
        xfer       = x;
        if (m_prev && !x) begin
            m_recv         = 1 - m_recv;
            m_cnt[m_recv]  = 0;
        end
        m_prev = x;
        if (!f) begin
            s = 1 - m_recv;
            if (m_cnt[s] > 0) begin
                m_cnt[s] = m_cnt[s] - 1;
                m_out    = m_mem[s][m_cnt[s]];
                m_uf     = 1'b0;
            end else begin
                m_out = '0;
                m_uf  = 1'b1;
            end
            if (m_cnt[m_recv] < D) begin
                m_mem[m_recv][m_cnt[m_recv]] = d;
                m_cnt[m_recv] = m_cnt[m_recv] + 1;
            end
        end
        q.push_back('{val: m_out, uf: m_uf, due: cyc + 2, tag: tag});
    endtask

    // Monitor: samples after each rising edge and compares due entries
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (q.size() > 0 && q[0].due == cyc) begin
                e = q.pop_front();
                check(e.tag, rev_sample, rev_empty_read, e.val, e.uf);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", rev_sample, rev_empty_read, '0, 1'b0);

        // R6 / R4: collect with xfer high; replay stack empty; rising edge no swap
        for (int i = 1; i <= 5; i++) step(W'(100 + i), 1'b0, 1'b1, "R6");
        // R3: falling edge swaps, newest sample replays first
        step(W'(106), 1'b0, 1'b0, "R3");
        step(W'(107), 1'b0, 1'b0, "R2");
        // R7: freeze mid replay, swap hidden under the freeze
        step(W'(200), 1'b1, 1'b0, "R7");
        step(W'(201), 1'b1, 1'b1, "R7");
        step(W'(202), 1'b1, 1'b0, "R7");
        step(W'(108), 1'b0, 1'b0, "R7");
        // R5: leftover samples of the old replay stack never reappear
        step(W'(109), 1'b0, 1'b0, "R5");
        step(W'(110), 1'b0, 1'b0, "R5");
        // R4: rising edge alone does not swap
        step(W'(111), 1'b0, 1'b1, "R4");
        step(W'(112), 1'b0, 1'b0, "R3");
        // R4: xfer held low causes no repeat swap
        for (int i = 113; i <= 117; i++) step(W'(i), 1'b0, 1'b0, "R4");
        // R8: overfill the collecting stack, then replay it completely
        step(W'(300), 1'b0, 1'b1, "R8");
        step(W'(301), 1'b0, 1'b0, "R8");
        for (int i = 2; i <= 21; i++) step(W'(300 + i), 1'b0, 1'b0, "R8");
        step(W'(400), 1'b0, 1'b1, "R8");
        step(W'(401), 1'b0, 1'b0, "R8");
        for (int i = 0; i < 17; i++) step(W'(500 + i), 1'b0, 1'b0, "R8");
        // R7: frozen tail keeps the output steady
        for (int i = 0; i < 3; i++) step(W'(700 + i), 1'b1, 1'b1, "R7");

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule